// File: doc/BRIEF.md
# Byte-Mapped Seconds Counter Real-Time Clock

This block keeps wall-clock time as a single free-running binary seconds count and raises an alarm interrupt when that count reaches a programmed value. It has no oscillator and no prescaler. A one-cycle pulse on `tick_i`, already in the `clk` domain and arriving once per second, advances the count. Conversion to calendar time is left to software.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe, a read strobe and read data. Every access completes in the cycle it is presented. The port has no valid/ready handshake and never applies back-pressure. Read data is registered: it appears after the clock edge that samples `rd_en_i` and holds until the next read. With the default of four bytes the map is:

- 0x0: control. Bit 7 runs the counter and bit 1 arms the alarm.
- 0x1: alarm status in bit 0.
- 0x2–0x5: time staging bytes.
- 0x6–0x9: live count bytes.
- 0xA–0xD: alarm compare bytes.

All multi-byte fields are little-endian, so the lowest address holds the least significant byte. To set the time, software writes 0x00 to the low staging byte, then the three upper staging bytes, then the real low byte. Writing the low staging byte loads the whole count.

Reading the count over the byte port is not atomic. Software reads all four live bytes and then reads the low byte again. If the second value is smaller, a carry happened between the reads and software repeats the read.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the count, staging bytes, alarm bytes, control bits and alarm status are all zero, and `irq_o` is low.
- R2: A read at 0x6+i returns byte i of the live count, where byte 0 is bits 7:0. The value is the count at the sampling edge, so re-reading the low byte after a tick shows a carry.
- R3: Writes to staging bytes 0x3–0x5 only store the byte. A write to 0x2 loads the count at that edge with the three stored upper bytes above the written data byte. Staging bytes read back what was written.
- R4: While control bit 7 is 1, each `tick_i` pulse adds one to the count, and 0xFFFFFFFF wraps to 0.
- R5: While control bit 7 is 0, `tick_i` leaves the count unchanged.
- R6: A write to 0x2 in the same cycle as a tick loads the written value and discards the increment.
- R7: When control bit 1 is 1 and the count begins to equal the alarm value, status bit 0 at 0x1 becomes 1 on the following edge.
- R8: `irq_o` equals status AND control bit 1. Writing 0 to bit 0 of 0x1 clears the status, and writing 1 has no effect. A match that persists after a clear does not set the status again.
- R9: While control bit 1 is 0, a count/alarm equality sets no status and `irq_o` stays low.
- R10: The alarm bytes at 0xA–0xD read back what was written, and writing zeros to all four returns the alarm value to zero.
- R11: Reads of unmapped addresses 0xE–0xF return 0x00. Control reads return only bits 7 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Alarm interrupt, level high |

## Verification
A time load through the low staging byte and a counting tick can fall in the same cycle. The bench drives both on one edge and expects the loaded value, with no increment, when the count is read back. A status clear can also coincide with a match that is still in force. The bench writes 0 to the status bit while the count still equals the alarm value and expects `irq_o` to stay low over the following cycles.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned A_CTRL       = 0;
  localparam int unsigned A_STAT       = 1;
  localparam int unsigned STAGE_BASE   = 2;
  localparam int unsigned CTRL_RUN_BIT = 7;
  localparam int unsigned CTRL_ALM_BIT = 1;
  localparam int unsigned STAT_BIT     = 0;
endpackage

// File: rtl/rtc_byte_bank.sv
module rtc_byte_bank #(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BASE   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [NBYTES*8-1:0]   value_o,
  output logic                  hit_o,
  output logic [7:0]            rd_byte_o
);
  logic [NBYTES-1:0] sel;
  logic [7:0]        bytes_q [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign sel[i] = (addr_i == ADDR_W'(BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bytes_q[i] <= '0;
      else if (wr_en_i && sel[i]) bytes_q[i] <= wdata_i;
    end
    assign value_o[i*8 +: 8] = bytes_q[i];
  end

  assign hit_o = |sel;

  always_comb begin
    rd_byte_o = '0;
    for (int i = 0; i < NBYTES; i++)
      if (sel[i]) rd_byte_o = bytes_q[i];
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_o <= '0;
    else if (load_i)           count_o <= load_val_i;
    else if (run_i && tick_i)  count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] alarm_i,
  input  logic         arm_i,
  input  logic         clr_i,
  output logic         status_o,
  output logic         irq_o
);
  logic match, match_q;

  assign match = arm_i && (count_i == alarm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= 1'b0;
      status_o <= 1'b0;
    end else begin
      match_q <= match;
      if (match && !match_q) status_o <= 1'b1;
      else if (clr_i)        status_o <= 1'b0;
    end
  end

  assign irq_o = status_o && arm_i;
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_sec_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int unsigned W        = NBYTES * BYTE_W;
  localparam int unsigned LIVE_BASE = STAGE_BASE + NBYTES;
  localparam int unsigned ALM_BASE = LIVE_BASE + NBYTES;

  logic         run, arm, status;
  logic [W-1:0] stage_val, alarm_val, count;
  logic         stage_hit, alarm_hit;
  logic [7:0]   stage_rd, alarm_rd, rd_mux;
  logic         commit, stat_clr;

  assign commit   = wr_en_i && (addr_i == ADDR_W'(STAGE_BASE));
  assign stat_clr = wr_en_i && (addr_i == ADDR_W'(A_STAT)) && !wdata_i[STAT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      arm <= 1'b0;
    end else if (wr_en_i && addr_i == ADDR_W'(A_CTRL)) begin
      run <= wdata_i[CTRL_RUN_BIT];
      arm <= wdata_i[CTRL_ALM_BIT];
    end
  end

  rtc_byte_bank #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .BASE(STAGE_BASE)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .value_o(stage_val), .hit_o(stage_hit), .rd_byte_o(stage_rd)
  );

  rtc_byte_bank #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .BASE(ALM_BASE)) u_alarm_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .value_o(alarm_val), .hit_o(alarm_hit), .rd_byte_o(alarm_rd)
  );

  rtc_sec_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_i), .load_i(commit),
    .load_val_i({stage_val[W-1:BYTE_W], wdata_i}), .count_o(count)
  );

  rtc_alarm_unit #(.W(W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .count_i(count), .alarm_i(alarm_val),
    .arm_i(arm), .clr_i(stat_clr), .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(A_CTRL)) begin
      rd_mux[CTRL_RUN_BIT] = run;
      rd_mux[CTRL_ALM_BIT] = arm;
    end else if (addr_i == ADDR_W'(A_STAT)) begin
      rd_mux[STAT_BIT] = status;
    end else if (stage_hit) begin
      rd_mux = stage_rd;
    end else if (alarm_hit) begin
      rd_mux = alarm_rd;
    end else begin
      for (int i = 0; i < NBYTES; i++)
        if (addr_i == ADDR_W'(LIVE_BASE + i)) rd_mux = count[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk #(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic [NBYTES*8-1:0] count,
  input logic [NBYTES*8-1:0] alarm_val,
  input logic              run,
  input logic              arm,
  input logic              status
);
  localparam int unsigned W       = NBYTES * 8;
  localparam int unsigned MAP_END = 2 + 3 * NBYTES;

  logic commit_seen;
  assign commit_seen = wr_en_i && (addr_i == ADDR_W'(2));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !commit_seen) |=> $stable(count));

  assert_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_i && !commit_seen) |=> (count == $past(count) + W'(1)));

  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_seen |=> (count[7:0] == $past(wdata_i)));

  assert_status_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(arm && (count == alarm_val)));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status && arm));

  assert_no_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> !irq_o);

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (int'(addr_i) >= MAP_END)) |=> (rdata_o == 8'h00));
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .count(count), .alarm_val(alarm_val), .run(run), .arm(arm), .status(status)
);

// File: tb/rtc_sec_core_tb.sv
module rtc_sec_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_sec_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] v);
    wr(4'h2, 8'h00);
    wr(4'h3, v[15:8]);
    wr(4'h4, v[23:16]);
    wr(4'h5, v[31:24]);
    wr(4'h2, v[7:0]);
  endtask

  task automatic read_time(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(6 + i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), b);
      chk("R1 register zero after reset", {24'b0, b}, 32'h0);
    end
  endtask

  task automatic t_load();
    logic [31:0] v;
    logic [7:0]  b;
    wr(4'h0, 8'h80);
    wr(4'h3, 8'hAA);
    read_time(v);
    chk("R3 upper staging write alone leaves count", v, 32'h0);
    set_time(32'h12345678);
    read_time(v);
    chk("R3 R2 loaded count little-endian", v, 32'h12345678);
    rd(4'h5, b);
    chk("R3 staging byte readback", {24'b0, b}, 32'h12);
    rd(4'h0, b);
    chk("R11 control readback", {24'b0, b}, 32'h80);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    set_time(32'h000000FE);
    pulse_tick(); pulse_tick(); pulse_tick();
    read_time(v);
    chk("R4 three ticks", v, 32'h00000101);
    set_time(32'hFFFFFFFF);
    pulse_tick();
    read_time(v);
    chk("R4 wrap to zero", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    set_time(32'h00001000);
    wr(4'h0, 8'h00);
    pulse_tick(); pulse_tick();
    read_time(v);
    chk("R5 halted count holds", v, 32'h00001000);
    wr(4'h0, 8'h80);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(4'h3, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h00);
    @(negedge clk);
    addr_i = 4'h2; wdata_i = 8'h40; wr_en_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    read_time(v);
    chk("R6 load beats tick", v, 32'h00000040);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    logic [7:0]  b0;
    set_time(32'h000001FF);
    read_time(v);
    chk("R2 pre-carry read", v, 32'h000001FF);
    pulse_tick();
    rd(4'h6, b0);
    chk("R2 low byte reread shows carry", {31'b0, (b0 < v[7:0])}, 32'h1);
    read_time(v);
    chk("R2 repeated read", v, 32'h00000200);
  endtask

  task automatic t_alarm();
    logic [7:0] b;
    set_time(32'h00000009);
    wr(4'hA, 8'h0A); wr(4'hB, 8'h00); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    wr(4'h0, 8'h82);
    chk("R9 no irq before match", {31'b0, irq_o}, 32'h0);
    pulse_tick();
    chk("R7 status not yet set in match cycle", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R7 R8 irq one cycle after match", {31'b0, irq_o}, 32'h1);
    rd(4'h1, b);
    chk("R7 status bit", {24'b0, b}, 32'h1);
    wr(4'h1, 8'h01);
    chk("R8 writing 1 keeps status", {31'b0, irq_o}, 32'h1);
    wr(4'h1, 8'h00);
    repeat (4) @(negedge clk);
    chk("R8 cleared and not re-set during same match", {31'b0, irq_o}, 32'h0);
    rd(4'h1, b);
    chk("R8 status reads clear", {24'b0, b}, 32'h0);
  endtask

  task automatic t_disarmed();
    logic [7:0] b;
    wr(4'h0, 8'h80);
    set_time(32'h00000013);
    wr(4'hA, 8'h14);
    pulse_tick();
    repeat (3) @(negedge clk);
    chk("R9 disarmed irq low", {31'b0, irq_o}, 32'h0);
    rd(4'h1, b);
    chk("R9 disarmed status clear", {24'b0, b}, 32'h0);
  endtask

  task automatic t_alarm_bank();
    logic [7:0] b;
    wr(4'hC, 8'h5C);
    rd(4'hC, b);
    chk("R10 alarm byte readback", {24'b0, b}, 32'h5C);
    for (int i = 0; i < 4; i++) wr(4'(10 + i), 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(4'(10 + i), b);
      chk("R10 alarm cleared to zero", {24'b0, b}, 32'h0);
    end
  endtask

  task automatic t_unmapped();
    logic [7:0] b;
    wr(4'hE, 8'hFF);
    rd(4'hE, b);
    chk("R11 unmapped 0xE", {24'b0, b}, 32'h0);
    rd(4'hF, b);
    chk("R11 unmapped 0xF", {24'b0, b}, 32'h0);
    wr(4'h0, 8'hFF);
    rd(4'h0, b);
    chk("R11 control only bits 7 and 1", {24'b0, b}, 32'h82);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_tick();
    t_hold();
    t_priority();
    t_carry();
    t_alarm();
    t_disarmed();
    t_alarm_bank();
    t_unmapped();
    finish_run();
  end
endmodule